// File: doc/BRIEF.md
# 64-bit Shift Unit with Signed Overflow Flag

This block performs the four shift operations of an integer datapath on a 64-bit operand: a signed left shift that reports integer overflow, an unsigned left shift with the same result bits and no overflow check, an arithmetic right shift and a logical right shift. A two-bit operation code picks the operation. The shift distance is unsigned and comes either from a full 64-bit register value or from an 8-bit immediate field, picked by a select input.

Distances of 64 and above are not reduced modulo the word width. They saturate: every bit of the operand leaves the word, so left shifts and the logical right shift give zero, the arithmetic right shift gives a word of sign copies, and the signed left shift flags overflow whenever the operand was non-zero. Operands are taken on a clock edge where the valid strobe is high, and the result, the overflow flag and a matching valid pulse appear one clock later, ready for the writeback and exception logic around the unit.

Top module: `shift_ovf_unit`

## Requirements
- R1: After reset, and in any cycle following an edge with `in_valid` low, `out_valid` is 0; reset clears `result` and `ovf` to 0, and `result`/`ovf` keep their last values across cycles with no valid input.
- R2: An operation sampled with `in_valid` high at a clock edge shows its `result` and `ovf` with `out_valid` high right after the next clock edge, exactly one cycle later.
- R3: With `use_imm` = 1 the distance is `amt_imm` zero-extended to 64 bits; with `use_imm` = 0 it is `amt_reg`, and the unused source has no effect.
- R4: Opcode 00 (signed left) for a distance k below 64 returns the operand moved k places toward the MSB with zeros entering at bit 0.
- R5: Opcode 00 raises `ovf` when, for k below 64, bits [63:63-k] of the operand are not all equal to bit 63 (the true product by 2^k leaves the signed 64-bit range).
- R6: Opcode 01 (unsigned left) returns the same bits as opcode 00 and never raises `ovf`.
- R7: Opcode 10 (arithmetic right) moves the operand k places toward bit 0 with copies of bit 63 entering at the top, which equals division by 2^k rounded toward negative infinity.
- R8: Opcode 11 (logical right) moves the operand k places toward bit 0 with zeros entering at the top.
- R9: For a distance of 64 or more (any value up to 2^64-1), opcodes 00, 01 and 11 return all zeros, and opcode 10 returns 0 for a non-negative operand and all ones for a negative operand.
- R10: For a distance of 64 or more, opcode 00 raises `ovf` exactly when the operand is non-zero.
- R11: `ovf` is 0 for every result of opcodes 01, 10 and 11.
- R12: A distance of zero returns the operand unchanged with `ovf` = 0 for every opcode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operands and opcode are taken at this edge |
| op | input | 2 | 00 signed left, 01 unsigned left, 10 arithmetic right, 11 logical right |
| use_imm | input | 1 | 1 selects `amt_imm` as distance, 0 selects `amt_reg` |
| data_in | input | 64 | Operand to be shifted |
| amt_reg | input | 64 | Unsigned distance from a register value |
| amt_imm | input | 8 | Unsigned immediate distance |
| out_valid | output | 1 | High for one cycle when `result` and `ovf` are new |
| result | output | 64 | Shifted operand |
| ovf | output | 1 | Integer overflow of the signed left shift |

## Verification
The assertions assume that the distance, opcode and operand are known (not X) in any cycle where `in_valid` is high and that reset is applied before the first strobe; they make no assumption about inputs when the strobe is low. The stimulus always drives every input with defined values, scrambles the unused distance source and idle-cycle inputs on purpose, and weights the random distances toward 0, 63, 64 and very large register values so the saturation edge is crossed from both sides. Operands are drawn both as full random words and as small sign-extended values so that signed left shifts both keep and lose their range.

// File: rtl/shu_pkg.sv
package shu_pkg;

  localparam int DATA_W = 64;
  localparam int IMM_W  = 8;

  typedef enum logic [1:0] {
    OP_SHL_S = 2'b00,
    OP_SHL_U = 2'b01,
    OP_SHR_A = 2'b10,
    OP_SHR_L = 2'b11
  } shu_op_e;

  // Operation moves bits toward bit 0.
  function automatic logic op_is_right(input shu_op_e o);
    return o[1];
  endfunction

  // Only the signed left shift checks range.
  function automatic logic op_checks_range(input shu_op_e o);
    return (o == OP_SHL_S);
  endfunction

  // Bit that enters at the top on a right shift.
  function automatic logic op_fill_bit(input shu_op_e o, input logic sign_bit);
    return (o == OP_SHR_A) & sign_bit;
  endfunction

endpackage

// File: rtl/shu_amount.sv
module shu_amount #(
  parameter int DATA_W = shu_pkg::DATA_W,
  parameter int IMM_W  = shu_pkg::IMM_W,
  localparam int SH_W  = $clog2(DATA_W)
) (
  input  logic              use_imm,
  input  logic [DATA_W-1:0] amt_reg,
  input  logic [IMM_W-1:0]  amt_imm,
  output logic [SH_W-1:0]   shamt,
  output logic              sat,
  output logic              is_zero
);

  logic [DATA_W-1:0] eff_amt;

  always_comb begin
    if (use_imm) eff_amt = {{(DATA_W-IMM_W){1'b0}}, amt_imm};
    else         eff_amt = amt_reg;
  end

  // Any bit at or above SH_W means the distance covers the whole word.
  assign sat     = |eff_amt[DATA_W-1:SH_W];
  assign shamt   = eff_amt[SH_W-1:0];
  assign is_zero = (eff_amt == '0);

endmodule

// File: rtl/shu_barrel.sv
module shu_barrel #(
  parameter int DATA_W = shu_pkg::DATA_W,
  localparam int SH_W  = $clog2(DATA_W)
) (
  input  logic [DATA_W-1:0] data,
  input  logic [SH_W-1:0]   shamt,
  input  logic              sat,
  input  logic              dir_right,
  input  logic              fill_bit,
  output logic [DATA_W-1:0] shifted
);

  localparam logic [DATA_W-1:0] ALL_ONES = '1;

  logic [SH_W:0][DATA_W-1:0] stg;

  assign stg[0] = data;

  generate
    for (genvar i = 0; i < SH_W; i++) begin : g_stage
      localparam int STEP = 1 << i;
      logic [DATA_W-1:0] top_fill;
      logic [DATA_W-1:0] moved;

      assign top_fill = fill_bit ? ~(ALL_ONES >> STEP) : '0;

      always_comb begin
        if (dir_right) moved = (stg[i] >> STEP) | top_fill;
        else           moved = stg[i] << STEP;
      end

      assign stg[i+1] = shamt[i] ? moved : stg[i];
    end
  endgenerate

  always_comb begin
    if (sat) shifted = (dir_right && fill_bit) ? ALL_ONES : '0;
    else     shifted = stg[SH_W];
  end

endmodule

// File: rtl/shu_ovf_check.sv
module shu_ovf_check #(
  parameter int DATA_W = shu_pkg::DATA_W,
  localparam int SH_W  = $clog2(DATA_W)
) (
  input  logic [DATA_W-1:0] data,
  input  logic [SH_W-1:0]   shamt,
  input  logic              sat,
  input  logic              enable,
  output logic              ovf
);

  localparam logic [DATA_W-1:0] ALL_ONES = '1;

  logic [DATA_W-1:0] differs;
  logic [DATA_W-1:0] window;
  logic [SH_W:0]     span;
  logic              in_range_bad;

  // Bits that disagree with the sign bit.
  assign differs = data ^ {DATA_W{data[DATA_W-1]}};
  // Window covers the k departing bits plus the new sign position.
  assign span    = (SH_W+1)'(shamt) + (SH_W+1)'(1);
  assign window  = ~(ALL_ONES >> span);
  assign in_range_bad = |(differs & window);

  always_comb begin
    if (!enable)  ovf = 1'b0;
    else if (sat) ovf = |data;
    else          ovf = in_range_bad;
  end

endmodule

// File: rtl/shift_ovf_unit.sv
module shift_ovf_unit #(
  parameter int DATA_W = shu_pkg::DATA_W,
  parameter int IMM_W  = shu_pkg::IMM_W,
  localparam int SH_W  = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [1:0]        op,
  input  logic              use_imm,
  input  logic [DATA_W-1:0] data_in,
  input  logic [DATA_W-1:0] amt_reg,
  input  logic [IMM_W-1:0]  amt_imm,
  output logic              out_valid,
  output logic [DATA_W-1:0] result,
  output logic              ovf
);
  import shu_pkg::*;

  shu_op_e           op_e;
  logic [SH_W-1:0]   shamt;
  logic              amt_sat;
  logic              amt_zero;
  logic              dir_right;
  logic              fill_bit;
  logic              range_chk;
  logic [DATA_W-1:0] shifted;
  logic              ovf_raw;

  logic              vld_q;
  logic [DATA_W-1:0] res_q;
  logic              ovf_q;
  shu_op_e           op_q;

  assign op_e      = shu_op_e'(op);
  assign dir_right = op_is_right(op_e);
  assign fill_bit  = op_fill_bit(op_e, data_in[DATA_W-1]);
  assign range_chk = op_checks_range(op_e);

  shu_amount #(.DATA_W(DATA_W), .IMM_W(IMM_W)) u_amount (
    .use_imm (use_imm),
    .amt_reg (amt_reg),
    .amt_imm (amt_imm),
    .shamt   (shamt),
    .sat     (amt_sat),
    .is_zero (amt_zero)
  );

  shu_barrel #(.DATA_W(DATA_W)) u_barrel (
    .data      (data_in),
    .shamt     (shamt),
    .sat       (amt_sat),
    .dir_right (dir_right),
    .fill_bit  (fill_bit),
    .shifted   (shifted)
  );

  shu_ovf_check #(.DATA_W(DATA_W)) u_ovf (
    .data   (data_in),
    .shamt  (shamt),
    .sat    (amt_sat),
    .enable (range_chk),
    .ovf    (ovf_raw)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      res_q <= '0;
      ovf_q <= 1'b0;
      op_q  <= OP_SHL_S;
    end else begin
      vld_q <= in_valid;
      if (in_valid) begin
        res_q <= shifted;
        ovf_q <= ovf_raw;
        op_q  <= op_e;
      end
    end
  end

  assign out_valid = vld_q;
  assign result    = res_q;
  assign ovf       = ovf_q;

  AST_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid); // R2
  AST_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid && $stable(result) && $stable(ovf)); // R1
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && (op_q != OP_SHL_S) |-> !ovf); // R11
  AST_ZERO_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && amt_zero |=> (result == $past(data_in)) && !ovf); // R12
  AST_SAT_LEFT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && amt_sat && (op != 2'b10) |=> result == '0); // R9
  AST_SAT_ARITH: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && amt_sat && (op == 2'b10) |=> result == {DATA_W{$past(data_in[DATA_W-1])}}); // R9
  AST_SAT_OVF: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && amt_sat && (op == 2'b00) |=> ovf == ($past(data_in) != '0)); // R10

endmodule

// File: tb/shift_ovf_unit_test.sv
module shift_ovf_unit_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [1:0]  op = 2'b00;
  logic        use_imm = 1'b0;
  logic [63:0] data_in = '0;
  logic [63:0] amt_reg = '0;
  logic [7:0]  amt_imm = '0;
  logic        out_valid;
  logic [63:0] result;
  logic        ovf;

  int total = 0;
  int bad = 0;

  always #5 clk = ~clk;

  shift_ovf_unit uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op), .use_imm(use_imm),
    .data_in(data_in), .amt_reg(amt_reg), .amt_imm(amt_imm),
    .out_valid(out_valid), .result(result), .ovf(ovf)
  );

  function automatic logic [63:0] ref_res(input logic [1:0] o, input logic [63:0] d,
                                          input logic [63:0] a);
    case (o)
      2'b00, 2'b01: return d << a;
      2'b10:        return 64'($signed(d) >>> a);
      default:      return d >> a;
    endcase
  endfunction

  // Overflow: shifting back arithmetically must recover the operand.
  function automatic logic ref_ovf(input logic [1:0] o, input logic [63:0] d,
                                   input logic [63:0] a);
    logic [63:0] back;
    if (o != 2'b00) return 1'b0;
    if (a >= 64) return d != 0;
    back = 64'($signed(d << a) >>> a);
    return back != d;
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic string op_tag(input logic [1:0] o, input logic [63:0] a);
    if (a == 0) return "R12";
    if (a >= 64) return (o == 2'b00) ? "R10" : "R9";
    case (o)
      2'b00:   return "R4";
      2'b01:   return "R6";
      2'b10:   return "R7";
      default: return "R8";
    endcase
  endfunction

  task automatic run_one(input logic [1:0] o, input logic ui, input logic [63:0] d,
                         input logic [63:0] ar, input logic [7:0] ai);
    logic [63:0] a;
    string t;
    a = ui ? {56'd0, ai} : ar;
    t = op_tag(o, a);
    op = o; use_imm = ui; data_in = d; amt_reg = ar; amt_imm = ai; in_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    chk("R2 out_valid", 64'(out_valid), 64'd1);
    chk({t, " result"}, result, ref_res(o, d, a));
    chk((o == 2'b00) ? {t, " R5 ovf"} : {t, " R11 ovf"}, 64'(ovf), 64'(ref_ovf(o, d, a)));
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : main
    logic [63:0] keep_r;
    logic        keep_o;
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 reset out_valid", 64'(out_valid), 64'd0);
    chk("R1 reset result", result, 64'd0);
    chk("R1 reset ovf", 64'(ovf), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // Directed corners
    run_one(2'b00, 1'b0, 64'h0000_0000_0000_0001, 64'd63, 8'd0);     // R4 into sign: overflow
    run_one(2'b00, 1'b0, 64'hFFFF_FFFF_FFFF_FFFF, 64'd63, 8'd0);     // R5 -1<<63 fits
    run_one(2'b00, 1'b1, 64'h4000_0000_0000_0000, 64'd0, 8'd1);      // R5 sign flip
    run_one(2'b00, 1'b1, 64'hC000_0000_0000_0000, 64'd5, 8'd1);      // R3 imm used, R5 fits
    run_one(2'b01, 1'b1, 64'h4000_0000_0000_0000, 64'd0, 8'd1);      // R6 no ovf
    run_one(2'b10, 1'b0, 64'h8000_0000_0000_0000, 64'd4, 8'd9);      // R7 R3 reg used
    run_one(2'b11, 1'b0, 64'h8000_0000_0000_0000, 64'd4, 8'd9);      // R8
    run_one(2'b00, 1'b0, 64'h0000_0000_0000_0000, 64'd64, 8'd0);     // R10 zero operand
    run_one(2'b00, 1'b0, 64'h0000_0000_0000_0002, 64'hFFFF_FFFF_FFFF_FFFF, 8'd0); // R10
    run_one(2'b00, 1'b1, 64'h0000_0000_0000_0002, 64'd0, 8'd200);    // R10 via imm
    run_one(2'b01, 1'b0, 64'hFFFF_FFFF_FFFF_FFFF, 64'd64, 8'd0);     // R9
    run_one(2'b10, 1'b0, 64'h8000_0000_0000_0001, 64'h1_0000_0000, 8'd0); // R9 neg
    run_one(2'b10, 1'b1, 64'h7FFF_FFFF_FFFF_FFFF, 64'd0, 8'd64);     // R9 pos
    run_one(2'b11, 1'b1, 64'hFFFF_FFFF_FFFF_FFFF, 64'd0, 8'd255);    // R9
    for (int o = 0; o < 4; o++)
      run_one(2'(o), 1'b0, 64'h8123_4567_89AB_CDEF, 64'd0, 8'd77);   // R12

    // R1: idle cycle with scrambled inputs keeps outputs
    keep_r = result; keep_o = ovf;
    op = 2'b11; data_in = 64'hDEAD_BEEF_0000_1111; amt_reg = 64'd3; use_imm = 1'b0;
    @(posedge clk);
    @(negedge clk);
    chk("R1 idle out_valid", 64'(out_valid), 64'd0);
    chk("R1 idle result hold", result, keep_r);
    chk("R1 idle ovf hold", 64'(ovf), 64'(keep_o));

    // Constrained random
    for (int n = 0; n < 600; n++) begin
      logic [63:0] d, ar;
      logic [7:0]  ai;
      logic [1:0]  o;
      logic        ui;
      int          pick;
      o  = 2'($urandom);
      ui = 1'($urandom);
      ai = 8'($urandom);
      pick = int'($urandom % 6);
      case (pick)
        0: ar = 64'($urandom % 64);
        1: ar = 64'd63;
        2: ar = 64'd64;
        3: ar = {$urandom, $urandom};
        4: ar = 64'd0;
        default: ar = 64'($urandom % 70);
      endcase
      if ($urandom % 2) d = {$urandom, $urandom};
      else d = 64'($signed(16'($urandom)));
      run_one(o, ui, d, ar, ai);
      if ($urandom % 4 == 0) begin
        keep_r = result;
        data_in = {$urandom, $urandom};
        @(posedge clk);
        @(negedge clk);
        chk("R1 gap out_valid", 64'(out_valid), 64'd0);
        chk("R1 gap result hold", result, keep_r);
      end
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule